// File: doc/BRIEF.md
# Indexed Effective-Address Unit

This block turns an indexed-addressing postbyte and up to two extension bytes into a 16-bit effective address. It decodes the postbyte, picks one of four 16-bit base registers (X, Y, SP, PC), adds the decoded offset and returns the result. The offset is a short signed constant, a 9-bit or 16-bit constant, an unsigned 8-bit accumulator (A or B), or the 16-bit accumulator D. Auto pre/post increment and decrement forms also return an updated value to write back to the base register. Two indirect forms use the sum as the address of a 16-bit pointer. The unit fetches that pointer with two byte reads through a one-cycle-latency read port.

The surrounding core presents `start_i` for one cycle together with the postbyte, the extension bytes and the current register and accumulator values. It holds these inputs stable until `done_o`. The extension byte count is decoded from the postbyte alone, so the fetch logic can use it before the address is ready. Direct forms finish in one cycle. Indirect forms finish four cycles after the start.

Top module: `idx_ea_unit`

## Requirements
- R1: After reset `done_o`, `wb_en_o`, `illegal_o` and `mem_req_o` are 0 and `ea_o` is 0.
- R2: The base field selects the register: 00 = X, 01 = Y, 10 = SP, 11 = PC. It sits in postbyte bits [7:6] for the short and auto-update forms and in bits [4:3] when bits [7:5] are 111.
- R3: A postbyte with bit 5 = 0 adds bits [4:0] to the base as a two's-complement offset (-16..+15). It uses no extension bytes.
- R4: A postbyte 111rr0zs with z = 0 adds a 9-bit offset. The sign comes from bit 0 and the low 8 bits from the first extension byte. The extension count is 1.
- R5: A postbyte 111rr010 adds a 16-bit offset whose high byte is the first extension byte and whose low byte is the second. The extension count is 2.
- R6: A postbyte rr1pnnnn with rr other than 11 is auto-update. nnnn 0000..0111 means +1..+8 and 1000..1111 means -8..-1. `wb_en_o` is 1 with `wb_sel_o` = rr and `wb_data_o` = base + step. For p = 0 (pre) the address is base + step. For p = 1 (post) the address is the original base.
- R7: A postbyte 111rr1aa adds an accumulator: aa = 00 zero-extended A, aa = 01 zero-extended B, aa = 10 D = {A,B}. Only auto-update asserts `wb_en_o`.
- R8: The indirect forms are 111rr011 (16-bit offset) and 111rr111 (D offset). They issue byte reads at sum and sum+1 on two consecutive cycles. The address returned is {byte at sum, byte at sum+1}. `done_o` pulses four cycles after the start cycle.
- R9: A direct form pulses `done_o` in the cycle after the start cycle, with `ea_o` and the write-back outputs valid.
- R10: All sums, including the second pointer address, wrap modulo 2^16.
- R11: A `start_i` while an indirect fetch is in progress is dropped. `illegal_o` pulses in the next cycle and the running fetch completes unchanged.
- R12: `ext_cnt_o` reflects the current `postbyte_i` combinationally: 2 for 111rr01x, 1 for 111rr00x, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Postbyte and operands valid, one-cycle pulse |
| postbyte_i | input | 8 | Indexed postbyte |
| ext0_i | input | 8 | First extension byte |
| ext1_i | input | 8 | Second extension byte |
| x_i | input | 16 | Index register X |
| y_i | input | 16 | Index register Y |
| sp_i | input | 16 | Stack pointer |
| pc_i | input | 16 | Program counter |
| acc_a_i | input | 8 | Accumulator A |
| acc_b_i | input | 8 | Accumulator B |
| mem_req_o | output | 1 | Pointer byte read request |
| mem_addr_o | output | 16 | Pointer byte read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| ea_o | output | 16 | Effective address |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_sel_o | output | 2 | Write-back register select (rr encoding) |
| wb_data_o | output | 16 | Updated base register value |
| ext_cnt_o | output | 2 | Extension bytes consumed by the postbyte |
| illegal_o | output | 1 | Start request dropped while busy |
| done_o | output | 1 | Result valid, one-cycle pulse |

## Verification
The vector table covers every base register under the short constant form, with offsets at both ends of the range. This shows that the field position and the sign extension are right. Positive and negative 9-bit offsets tell the postbyte sign bit apart from the extension byte. A PC-based 16-bit offset that overflows, and an indirect fetch whose pointer straddles 0xFFFF, exercise the wrap. Pre and post updates in both directions, at step sizes 1 and 8, separate the returned address from the write-back value. The accumulator cases use A = 0x80 to expose any sign extension. A start during a fetch checks that it is dropped and the running result survives.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int AW = 16;
  localparam int BW = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_RD0, ST_RD1, ST_RD2} st_e;

  typedef struct packed {
    logic [1:0]    base;
    logic [AW-1:0] offset;
    logic          auto_upd;
    logic          post;
    logic          indirect;
    logic [1:0]    ext_cnt;
  } dec_t;
endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_ea_pkg::*;
(
  input  logic [BW-1:0] pb_i,
  input  logic [BW-1:0] ext0_i,
  input  logic [BW-1:0] ext1_i,
  input  logic [BW-1:0] acc_a_i,
  input  logic [BW-1:0] acc_b_i,
  output dec_t          dec_o
);
  localparam int SHORT_W = 5;
  localparam int STEP_W  = 4;

  logic [AW-1:0] step;

  // nnnn: 0..7 -> +1..+8, 8..15 -> -8..-1
  always_comb begin
    if (pb_i[3]) step = {{(AW-STEP_W){1'b1}}, pb_i[STEP_W-1:0]};
    else         step = {{(AW-STEP_W){1'b0}}, pb_i[STEP_W-1:0]} + AW'(1);
  end

  always_comb begin
    dec_o = '0;
    if (!pb_i[5]) begin
      dec_o.base   = pb_i[7:6];
      dec_o.offset = {{(AW-SHORT_W){pb_i[4]}}, pb_i[SHORT_W-1:0]};
    end else if (pb_i[7:5] != 3'b111) begin
      dec_o.base     = pb_i[7:6];
      dec_o.auto_upd = 1'b1;
      dec_o.post     = pb_i[4];
      dec_o.offset   = step;
    end else begin
      dec_o.base = pb_i[4:3];
      if (!pb_i[2]) begin
        if (!pb_i[1]) begin
          dec_o.offset  = {{(AW-BW){pb_i[0]}}, ext0_i};
          dec_o.ext_cnt = 2'd1;
        end else begin
          dec_o.offset   = {ext0_i, ext1_i};
          dec_o.ext_cnt  = 2'd2;
          dec_o.indirect = pb_i[0];
        end
      end else begin
        unique case (pb_i[1:0])
          2'b00:   dec_o.offset = {{(AW-BW){1'b0}}, acc_a_i};
          2'b01:   dec_o.offset = {{(AW-BW){1'b0}}, acc_b_i};
          default: dec_o.offset = {acc_a_i, acc_b_i};
        endcase
        dec_o.indirect = pb_i[1] & pb_i[0];
      end
    end
  end
endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
  import idx_ea_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic [NREG-1:0][AW-1:0] regs_i,
  input  logic [$clog2(NREG)-1:0] sel_i,
  input  logic [AW-1:0]           offset_i,
  output logic [AW-1:0]           base_o,
  output logic [AW-1:0]           sum_o
);
  assign base_o = regs_i[sel_i];
  assign sum_o  = base_o + offset_i;
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    postbyte_i,
  input  logic [7:0]    ext0_i,
  input  logic [7:0]    ext1_i,
  input  logic [15:0]   x_i,
  input  logic [15:0]   y_i,
  input  logic [15:0]   sp_i,
  input  logic [15:0]   pc_i,
  input  logic [7:0]    acc_a_i,
  input  logic [7:0]    acc_b_i,
  output logic          mem_req_o,
  output logic [15:0]   mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [15:0]   ea_o,
  output logic          wb_en_o,
  output logic [1:0]    wb_sel_o,
  output logic [15:0]   wb_data_o,
  output logic [1:0]    ext_cnt_o,
  output logic          illegal_o,
  output logic          done_o
);
  localparam int NREG = 4;

  dec_t                   dec;
  logic [NREG-1:0][AW-1:0] regs;
  logic [AW-1:0]          base_val, sum;
  st_e                    st_q;
  logic [AW-1:0]          ptr_q, ea_q, wb_data_q;
  logic [BW-1:0]          hi_q;
  logic [1:0]             wb_sel_q;
  logic                   wb_en_q, done_q, illegal_q;

  assign regs = {pc_i, sp_i, y_i, x_i};

  idx_decode u_dec (
    .pb_i    (postbyte_i),
    .ext0_i  (ext0_i),
    .ext1_i  (ext1_i),
    .acc_a_i (acc_a_i),
    .acc_b_i (acc_b_i),
    .dec_o   (dec)
  );

  idx_addr_calc #(.NREG(NREG)) u_calc (
    .regs_i   (regs),
    .sel_i    (dec.base),
    .offset_i (dec.offset),
    .base_o   (base_val),
    .sum_o    (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ptr_q     <= '0;
      hi_q      <= '0;
      ea_q      <= '0;
      wb_data_q <= '0;
      wb_sel_q  <= '0;
      wb_en_q   <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      wb_en_q   <= 1'b0;
      illegal_q <= start_i && (st_q != ST_IDLE);
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (dec.indirect) begin
              ptr_q <= sum;
              st_q  <= ST_RD0;
            end else begin
              ea_q      <= (dec.auto_upd && dec.post) ? base_val : sum;
              wb_en_q   <= dec.auto_upd;
              wb_sel_q  <= dec.base;
              wb_data_q <= sum;
              done_q    <= 1'b1;
            end
          end
        end
        ST_RD0: st_q <= ST_RD1;
        ST_RD1: begin
          hi_q <= mem_rdata_i;
          st_q <= ST_RD2;
        end
        default: begin
          ea_q   <= {hi_q, mem_rdata_i};
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end

  assign mem_req_o  = (st_q == ST_RD0) || (st_q == ST_RD1);
  assign mem_addr_o = (st_q == ST_RD1) ? ptr_q + AW'(1) : ptr_q;
  assign ea_o       = ea_q;
  assign wb_en_o    = wb_en_q;
  assign wb_sel_o   = wb_sel_q;
  assign wb_data_o  = wb_data_q;
  assign ext_cnt_o  = dec.ext_cnt;
  assign illegal_o  = illegal_q;
  assign done_o     = done_q;
endmodule

// File: rtl/idx_ea_unit_chk.sv
module idx_ea_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic [15:0] mem_addr_o,
  input logic        wb_en_o,
  input logic        illegal_o,
  input logic        done_o
);
  // R8
  two_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |=> mem_req_o);

  // R10
  next_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mem_req_o) && mem_req_o) |-> mem_addr_o == $past(mem_addr_o) + 16'd1);

  // R8
  done_after_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_req_o) |=> done_o);

  // R9
  no_done_in_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o);

  // R6
  wb_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o);

  // R11
  drop_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_en_o);
endmodule

bind idx_ea_unit idx_ea_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .wb_en_o    (wb_en_o),
  .illegal_o  (illegal_o),
  .done_o     (done_o)
);

// File: tb/idx_ea_unit_bench.sv
module idx_ea_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  typedef struct packed {
    logic [7:0]  pb;
    logic [7:0]  e0;
    logic [7:0]  e1;
    logic [15:0] ea;      // sum for indirect rows
    logic        wb_en;
    logic [1:0]  wb_sel;
    logic [15:0] wb_data;
    logic [1:0]  ext;
    logic        ind;
  } vec_t;

  // X=1000 Y=2000 SP=3000 PC=4000 A=80 B=05
  localparam vec_t VECS [NVEC] = '{
    '{8'h05, 8'h00, 8'h00, 16'h1005, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0},
    '{8'h5F, 8'h00, 8'h00, 16'h1FFF, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0},
    '{8'h90, 8'h00, 8'h00, 16'h2FF0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0},
    '{8'hCF, 8'h00, 8'h00, 16'h400F, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0},
    '{8'hE0, 8'h34, 8'h00, 16'h1034, 1'b0, 2'd0, 16'h0000, 2'd1, 1'b0},
    '{8'hE9, 8'hFF, 8'h00, 16'h1FFF, 1'b0, 2'd0, 16'h0000, 2'd1, 1'b0},
    '{8'hF2, 8'h12, 8'h34, 16'h4234, 1'b0, 2'd0, 16'h0000, 2'd2, 1'b0},
    '{8'hFA, 8'hF0, 8'h00, 16'h3000, 1'b0, 2'd0, 16'h0000, 2'd2, 1'b0},
    '{8'hE4, 8'h00, 8'h00, 16'h1080, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0},
    '{8'hED, 8'h00, 8'h00, 16'h2005, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0},
    '{8'hF6, 8'h00, 8'h00, 16'hB005, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0},
    '{8'h20, 8'h00, 8'h00, 16'h1001, 1'b1, 2'd0, 16'h1001, 2'd0, 1'b0},
    '{8'h78, 8'h00, 8'h00, 16'h2000, 1'b1, 2'd1, 16'h1FF8, 2'd0, 1'b0},
    '{8'hAF, 8'h00, 8'h00, 16'h2FFF, 1'b1, 2'd2, 16'h2FFF, 2'd0, 1'b0},
    '{8'hB7, 8'h00, 8'h00, 16'h3000, 1'b1, 2'd2, 16'h3008, 2'd0, 1'b0},
    '{8'hE3, 8'h00, 8'h10, 16'h1010, 1'b0, 2'd0, 16'h0000, 2'd2, 1'b1},
    '{8'hEF, 8'h00, 8'h00, 16'hA005, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  pb = '0, e0 = '0, e1 = '0;
  logic [15:0] x = 16'h1000, y = 16'h2000, sp = 16'h3000, pc = 16'h4000;
  logic [7:0]  acc_a = 8'h80, acc_b = 8'h05;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] ea, wb_data;
  logic        wb_en, illegal, done;
  logic [1:0]  wb_sel, ext_cnt;
  logic [15:0] rd_addr [2];
  int          rd_cnt = 0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ea_unit u_idx_ea_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .postbyte_i(pb),
    .ext0_i(e0), .ext1_i(e1), .x_i(x), .y_i(y), .sp_i(sp), .pc_i(pc),
    .acc_a_i(acc_a), .acc_b_i(acc_b), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .ea_o(ea),
    .wb_en_o(wb_en), .wb_sel_o(wb_sel), .wb_data_o(wb_data),
    .ext_cnt_o(ext_cnt), .illegal_o(illegal), .done_o(done)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mem_byte(mem_addr);
      if (rd_cnt < 2) rd_addr[rd_cnt] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives one start and returns the number of negedges until done
  task automatic run(input logic [7:0] p, input logic [7:0] b0, input logic [7:0] b1,
                     output int lat);
    @(negedge clk);
    pb = p; e0 = b0; e1 = b1; start = 1'b1;
    rd_cnt = 0;
    #1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [15:0] exp_ea;
    #(CLK_PERIOD*2 + 2);
    // R1 reset state
    check("R1 done", {15'b0, done}, 16'h0);
    check("R1 wb_en", {15'b0, wb_en}, 16'h0);
    check("R1 illegal", {15'b0, illegal}, 16'h0);
    check("R1 mem_req", {15'b0, mem_req}, 16'h0);
    check("R1 ea", ea, 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      pb = VECS[i].pb; e0 = VECS[i].e0; e1 = VECS[i].e1;
      #1;
      // R12 count decoded before start
      check($sformatf("R12 ext_cnt v%0d", i), {14'b0, ext_cnt}, {14'b0, VECS[i].ext});
      run(VECS[i].pb, VECS[i].e0, VECS[i].e1, lat);
      if (VECS[i].ind) begin
        exp_ea = {mem_byte(VECS[i].ea), mem_byte(VECS[i].ea + 16'd1)};
        // R8 latency and pointer
        check($sformatf("R8 latency v%0d", i), 16'(lat), 16'd4);
        check($sformatf("R8 pointer v%0d", i), ea, exp_ea);
        check($sformatf("R8 first read v%0d", i), rd_addr[0], VECS[i].ea);
        check($sformatf("R8 second read v%0d", i), rd_addr[1], VECS[i].ea + 16'd1);
      end else begin
        // R9 single-cycle forms; R2 R3 R4 R5 R7 R10 in the address
        check($sformatf("R9 latency v%0d", i), 16'(lat), 16'd1);
        check($sformatf("R2 ea v%0d", i), ea, VECS[i].ea);
      end
      // R6 write-back only for auto-update, R7 none for accumulator
      check($sformatf("R6 wb_en v%0d", i), {15'b0, wb_en}, {15'b0, VECS[i].wb_en});
      if (VECS[i].wb_en) begin
        check($sformatf("R6 wb_sel v%0d", i), {14'b0, wb_sel}, {14'b0, VECS[i].wb_sel});
        check($sformatf("R6 wb_data v%0d", i), wb_data, VECS[i].wb_data);
      end
    end

    // R10 pointer straddling the top of memory: PC + BFFF = FFFF
    run(8'hFB, 8'hBF, 8'hFF, lat);
    check("R10 wrap pointer", ea, {mem_byte(16'hFFFF), mem_byte(16'h0000)});
    check("R10 wrap second read", rd_addr[1], 16'h0000);

    // R11 start during fetch is dropped
    @(negedge clk);
    pb = 8'hE3; e0 = 8'h00; e1 = 8'h20; start = 1'b1;
    @(negedge clk);
    pb = 8'h05; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 illegal pulse", {15'b0, illegal}, 16'h1);
    check("R11 no early done", {15'b0, done}, 16'h0);
    @(negedge clk);
    check("R11 illegal clears", {15'b0, illegal}, 16'h0);
    @(negedge clk);
    check("R11 fetch completes", {15'b0, done}, 16'h1);
    check("R11 result kept", ea, {mem_byte(16'h1020), mem_byte(16'h1021)});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule